// File: doc/BRIEF.md
# Capability List Walker

This block searches a configuration-space capability chain for a requested capability identifier. It reads the space one byte at a time through a read port with a request/acknowledge handshake. A start pulse supplies the identifier to look for and an instance number. The walker first reads the status byte to check that a capability chain is advertised. It then fetches the head pointer and follows the chain entry by entry.

The walk ends in one of four ways: the wanted entry is found, a pointer falls below the reserved header area, an entry carries the terminator identifier, or the hop bound is reached. At the end the block raises a one-cycle done pulse. Together with the pulse it gives a found flag and the 4-byte-aligned offset of the matching entry. The instance number lets software ask for the second, third and later entry with the same identifier. Repeating a search with a higher instance number steps through duplicates.

Top module: `cap_chain_walker`

## Requirements
- R1: A start pulse while idle latches the target identifier and instance number and raises busy. The first read issued is the status byte at address 0x06.
- R2: If bit 4 of the status byte (address 0x06) is 0, the walk finishes with found=0 and offset 0 after that single read.
- R3: The head pointer is read from address 0x34. Bits 1:0 of every pointer are forced to 0 before use as an address, so any reported offset has bits 1:0 equal to 0.
- R4: If a raw pointer value is below 0x40, the walk finishes with found=0. This covers the head pointer and every next pointer.
- R5: An entry whose identifier byte reads 0xFF ends the walk with found=0. This holds even when the target identifier is 0xFF.
- R6: At most MAX_HOPS entries (default 48) are examined. The walk then ends with found=0, so a looping chain costs at most 2 + 2*MAX_HOPS reads.
- R7: When an entry's identifier equals the target and it is the selected instance, the walk reports found=1 with the aligned entry address. Otherwise the next pointer is read from the aligned address plus one.
- R8: The instance input selects which matching entry is reported: 0 means the first, 1 the second, and so on. Earlier matches are passed over.
- R9: Only one read is outstanding at a time. Once raised, the read request and its address hold steady until an acknowledge is seen in the same cycle as the request, and the read data is taken in that cycle.
- R10: done_o is a one-cycle pulse, and found_o and offset_o are valid while it is high. A start pulse while busy has no effect on the walk or its result.
- R11: After reset, rd_req_o, done_o, busy_o and found_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Starts a walk when idle |
| target_id_i | input | 8 | Capability identifier to look for |
| instance_i | input | INST_W | Which matching entry to report (0 = first) |
| rd_req_o | output | 1 | Byte read request, held until acknowledged |
| rd_addr_o | output | 8 | Byte address of the pending read |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 8 | Read data byte |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Search result, valid with done_o |
| offset_o | output | 8 | Aligned offset of the matched entry, 0 when not found |

## Verification
Several end conditions can be decided on the same read, so the order in which they are judged matters. Searching for identifier 0xFF puts a terminator and a match on the same byte; the bench expects not-found. A self-looping chain whose identifier matches, searched with instance 47 and then 48, places the selected match exactly on the last permitted hop and then one past it; the bench expects found at offset 0x40 and then not-found. The scoreboard judges each case by result, offset and the number of completed reads. A second start issued in the middle of a long walk must leave the queued expectation unchanged.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned CFG_DW = 8;
  typedef logic [CFG_AW-1:0] cfg_addr_t;
  typedef logic [CFG_DW-1:0] cfg_byte_t;

  localparam cfg_addr_t STATUS_ADDR = 8'h06;
  localparam int unsigned CAP_FLAG_BIT = 4;
  localparam cfg_addr_t HEAD_ADDR   = 8'h34;
  localparam cfg_addr_t LIST_FLOOR  = 8'h40;
  localparam cfg_byte_t END_ID      = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STAT,
    S_HEAD,
    S_CHECK,
    S_ID,
    S_NEXT,
    S_DONE
  } walk_state_e;

  function automatic logic is_read_state(walk_state_e s);
    return (s == S_STAT) || (s == S_HEAD) || (s == S_ID) || (s == S_NEXT);
  endfunction
endpackage

// File: rtl/cw_read_port.sv
module cw_read_port
  import cw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      launch_i,
  input  cfg_addr_t launch_addr_i,
  output logic      rd_req_o,
  output cfg_addr_t rd_addr_o,
  input  logic      rd_ack_i,
  input  cfg_byte_t rd_data_i,
  output logic      rsp_valid_o,
  output cfg_byte_t rsp_data_o
);
  logic      req_q, req_d;
  cfg_addr_t addr_q, addr_d;

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    if (launch_i) begin
      req_d  = 1'b1;
      addr_d = launch_addr_i;
    end else if (req_q && rd_ack_i) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
    end
  end

  assign rd_req_o    = req_q;
  assign rd_addr_o   = addr_q;
  assign rsp_valid_o = req_q & rd_ack_i;
  assign rsp_data_o  = rd_data_i;

  // R9: a new read is only launched when nothing is outstanding or the current one completes
  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> (!req_q || rd_ack_i));

  // R9: unacknowledged request keeps its address
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !rd_ack_i) |=> (req_q && $stable(addr_q)));
endmodule

// File: rtl/cw_hop_counter.sv
module cw_hop_counter #(
  parameter int unsigned MAX_HOPS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic limit_o
);
  localparam int unsigned CW = $clog2(MAX_HOPS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_HOPS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign limit_o = (cnt_q == LIMIT);

  // R6: the hop count never passes the bound
  assert_hops_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R6: no further hop is taken once the bound is reached
  assert_no_hop_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |-> !limit_o);
endmodule

// File: rtl/cw_match_counter.sv
module cw_match_counter #(
  parameter int unsigned INST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              skip_i,
  input  logic [INST_W-1:0] want_i,
  output logic              select_o
);
  localparam logic [INST_W-1:0] SAT = '1;

  logic [INST_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                      cnt_d = '0;
    else if (skip_i && cnt_q != SAT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign select_o = (cnt_q == want_i);

  // R8: a match is only passed over when it is not the selected one
  assert_skip_not_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_i && !clr_i) |-> !select_o);
endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
  import cw_pkg::*;
#(
  parameter int unsigned MAX_HOPS = 48,
  parameter int unsigned INST_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        target_id_i,
  input  logic [INST_W-1:0] instance_i,
  output logic              rd_req_o,
  output logic [7:0]        rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [7:0]        offset_o
);
  walk_state_e       state_q, state_d;
  cfg_byte_t         ptr_q, ptr_d;
  cfg_byte_t         target_q, target_d;
  logic [INST_W-1:0] inst_q, inst_d;
  logic              found_q, found_d;
  cfg_addr_t         off_q, off_d;

  logic      hop_clr, hop_inc, hop_limit;
  logic      m_clr, m_skip, m_sel;
  logic      launch;
  cfg_addr_t launch_addr;
  logic      rsp_valid;
  cfg_byte_t rsp_data;
  cfg_addr_t entry_addr;

  assign entry_addr = {ptr_q[CFG_AW-1:2], 2'b00};

  cw_read_port u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_i     (launch),
    .launch_addr_i(launch_addr),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .rd_ack_i     (rd_ack_i),
    .rd_data_i    (rd_data_i),
    .rsp_valid_o  (rsp_valid),
    .rsp_data_o   (rsp_data)
  );

  cw_hop_counter #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (hop_clr),
    .inc_i  (hop_inc),
    .limit_o(hop_limit)
  );

  cw_match_counter #(.INST_W(INST_W)) u_matches (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (m_clr),
    .skip_i  (m_skip),
    .want_i  (inst_q),
    .select_o(m_sel)
  );

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    target_d = target_q;
    inst_d   = inst_q;
    found_d  = found_q;
    off_d    = off_q;
    hop_clr  = 1'b0;
    hop_inc  = 1'b0;
    m_clr    = 1'b0;
    m_skip   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          target_d = target_id_i;
          inst_d   = instance_i;
          found_d  = 1'b0;
          off_d    = '0;
          hop_clr  = 1'b1;
          m_clr    = 1'b1;
          state_d  = S_STAT;
        end
      end
      S_STAT: begin
        if (rsp_valid) begin
          state_d = rsp_data[CAP_FLAG_BIT] ? S_HEAD : S_DONE;
        end
      end
      S_HEAD: begin
        if (rsp_valid) begin
          ptr_d   = rsp_data;
          state_d = S_CHECK;
        end
      end
      S_CHECK: begin
        if (hop_limit || (ptr_q < LIST_FLOOR)) state_d = S_DONE;
        else                                   state_d = S_ID;
      end
      S_ID: begin
        if (rsp_valid) begin
          if (rsp_data == END_ID) begin
            state_d = S_DONE;
          end else if (rsp_data == target_q) begin
            if (m_sel) begin
              found_d = 1'b1;
              off_d   = entry_addr;
              state_d = S_DONE;
            end else begin
              m_skip  = 1'b1;
              state_d = S_NEXT;
            end
          end else begin
            state_d = S_NEXT;
          end
        end
      end
      S_NEXT: begin
        if (rsp_valid) begin
          ptr_d   = rsp_data;
          hop_inc = 1'b1;
          state_d = S_CHECK;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    launch      = is_read_state(state_d) && (state_d != state_q);
    launch_addr = '0;
    unique case (state_d)
      S_STAT:  launch_addr = STATUS_ADDR;
      S_HEAD:  launch_addr = HEAD_ADDR;
      S_ID:    launch_addr = entry_addr;
      S_NEXT:  launch_addr = entry_addr + 1'b1;
      default: launch_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      ptr_q    <= '0;
      target_q <= '0;
      inst_q   <= '0;
      found_q  <= 1'b0;
      off_q    <= '0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      target_q <= target_d;
      inst_q   <= inst_d;
      found_q  <= found_d;
      off_q    <= off_d;
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign found_o  = found_q;
  assign offset_o = off_q;

  // R1: an accepted start leaves the walker busy on the next cycle
  assert_start_accepted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R2: a clear capability flag ends the walk right away as not-found
  assert_no_list_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STAT && rsp_valid && !rsp_data[CAP_FLAG_BIT]) |=> (done_o && !found_o));

  // R3: a reported offset is aligned and above the header area
  assert_offset_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (offset_o[1:0] == 2'b00 && offset_o >= LIST_FLOOR));

  // R5: a terminator identifier never produces a match
  assert_terminator_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ID && rsp_valid && rsp_data == END_ID) |=> (done_o && !found_o));

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/cap_chain_walker_bench.sv
module cap_chain_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int INST_W = 6;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [7:0]        target_id;
  logic [INST_W-1:0] inst;
  logic              rd_req_o;
  logic [7:0]        rd_addr_o;
  logic              ack;
  logic [7:0]        rdata;
  logic              busy_o, done_o, found_o;
  logic [7:0]        offset_o;

  cap_chain_walker #(.MAX_HOPS(48), .INST_W(INST_W)) u_cap_chain_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .target_id_i(target_id),
    .instance_i (inst),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ack_i   (ack),
    .rd_data_i  (rdata),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .found_o    (found_o),
    .offset_o   (offset_o)
  );

  int checks = 0;
  int errors = 0;
  int n_reads = 0;
  int lat = 1;
  int cnt = 0;
  int dones = 0;
  int pushed = 0;
  int hs_bad = 0;
  logic [7:0] mem [256];

  logic  q_found [$];
  logic [7:0] q_off [$];
  int    q_reads [$];
  string q_tag [$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // responder with programmable latency
  always @(negedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      cnt <= 0;
    end else if (ack) begin
      ack <= 1'b0;
    end else if (rd_req_o) begin
      if (cnt >= lat) begin
        ack   <= 1'b1;
        rdata <= mem[rd_addr_o];
        cnt   <= 0;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  always @(posedge clk) if (rst_n && rd_req_o && ack) n_reads++;

  // R9 handshake watcher
  logic       prev_req = 1'b0;
  logic [7:0] prev_addr = 8'h00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req && !ack && (!rd_req_o || rd_addr_o != prev_addr)) hs_bad++;
      prev_req  = rd_req_o;
      prev_addr = rd_addr_o;
    end else begin
      prev_req = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each completion pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (q_tag.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10: unexpected done, actual 1 expected 0");
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " found"},  int'(found_o),  int'(q_found.pop_front()));
        check({t, " offset"}, int'(offset_o), int'(q_off.pop_front()));
        check({t, " reads"},  n_reads,        q_reads.pop_front());
      end
      dones++;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h06] = 8'h10;
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] id, input logic [7:0] nxt);
    mem[a]      = id;
    mem[a + 1]  = nxt;
  endtask

  task automatic walk(input logic [7:0] tgt, input logic [INST_W-1:0] k,
                      input logic ef, input logic [7:0] eo, input int er,
                      input string tag, input bit poke, input bit first_chk);
    q_found.push_back(ef);
    q_off.push_back(eo);
    q_reads.push_back(er);
    q_tag.push_back(tag);
    pushed++;
    @(negedge clk);
    n_reads   = 0;
    target_id = tgt;
    inst      = k;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (first_chk) begin
      check("R1 busy after start", int'(busy_o), 1);
      check("R1 first read addr", int'(rd_req_o) * 256 + int'(rd_addr_o), 256 + 8'h06);
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      target_id = 8'h01;
      inst      = '0;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (dones < pushed) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    target_id = 8'h00;
    inst = '0;
    clear_mem();
    repeat (3) @(negedge clk);
    check("R11 reset req",   int'(rd_req_o), 0);
    check("R11 reset done",  int'(done_o),   0);
    check("R11 reset busy",  int'(busy_o),   0);
    check("R11 reset found", int'(found_o),  0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: no capability list
    lat = 1;
    clear_mem();
    mem[8'h06] = 8'hEF;
    walk(8'h05, 0, 1'b0, 8'h00, 1, "R2 flag clear", 1'b0, 1'b0);

    // R7 / R3: simple chain 0x40 -> 0x50 -> 0x70 -> end
    clear_mem();
    mem[8'h34] = 8'h40;
    put(8'h40, 8'h01, 8'h50);
    put(8'h50, 8'h05, 8'h70);
    put(8'h70, 8'h0A, 8'h00);
    lat = 0;
    walk(8'h0A, 0, 1'b1, 8'h70, 7, "R7 third entry", 1'b0, 1'b1);
    lat = 3;
    walk(8'h05, 0, 1'b1, 8'h50, 5, "R7 second entry", 1'b0, 1'b0);
    walk(8'h22, 0, 1'b0, 8'h00, 8, "R4 end pointer", 1'b0, 1'b0);

    // R3: unaligned pointers
    clear_mem();
    mem[8'h34] = 8'h43;
    put(8'h40, 8'h01, 8'h5B);
    put(8'h58, 8'h0C, 8'h00);
    lat = 2;
    walk(8'h0C, 0, 1'b1, 8'h58, 5, "R3 aligned", 1'b0, 1'b0);

    // R5: terminator, including target equal to the terminator
    clear_mem();
    mem[8'h34] = 8'h40;
    put(8'h40, 8'h01, 8'h50);
    put(8'h50, 8'hFF, 8'h60);
    put(8'h60, 8'h0C, 8'h00);
    walk(8'h0C, 0, 1'b0, 8'h00, 5, "R5 terminator", 1'b0, 1'b0);
    walk(8'hFF, 0, 1'b0, 8'h00, 5, "R5 target FF", 1'b0, 1'b0);

    // R4: pointer below floor mid chain and at head
    clear_mem();
    mem[8'h34] = 8'h40;
    put(8'h40, 8'h01, 8'h3C);
    put(8'h3C, 8'h09, 8'h00);
    walk(8'h09, 0, 1'b0, 8'h00, 4, "R4 low next", 1'b0, 1'b0);
    mem[8'h34] = 8'h3F;
    walk(8'h09, 0, 1'b0, 8'h00, 2, "R4 low head", 1'b0, 1'b0);

    // R6: self loop against the hop bound
    clear_mem();
    mem[8'h34] = 8'h40;
    put(8'h40, 8'h01, 8'h40);
    lat = 1;
    walk(8'h02, 0,  1'b0, 8'h00, 98, "R6 loop bound", 1'b0, 1'b0);
    walk(8'h01, 47, 1'b1, 8'h40, 97, "R6 R8 last hop match", 1'b0, 1'b0);
    walk(8'h01, 48, 1'b0, 8'h00, 98, "R6 R8 past bound", 1'b0, 1'b0);

    // R10: start while busy is ignored
    walk(8'h02, 0, 1'b0, 8'h00, 98, "R10 start ignored", 1'b1, 1'b0);

    // R8: instance selection
    clear_mem();
    mem[8'h34] = 8'h40;
    put(8'h40, 8'h03, 8'h48);
    put(8'h48, 8'h07, 8'h60);
    put(8'h60, 8'h07, 8'h80);
    put(8'h80, 8'h07, 8'h00);
    lat = 4;
    walk(8'h07, 0, 1'b1, 8'h48, 5,  "R8 instance 0", 1'b0, 1'b0);
    walk(8'h07, 1, 1'b1, 8'h60, 7,  "R8 instance 1", 1'b0, 1'b0);
    walk(8'h07, 3, 1'b0, 8'h00, 10, "R8 instance 3", 1'b0, 1'b0);

    repeat (5) @(negedge clk);
    check("R10 no stray done", dones, pushed);
    check("R9 handshake violations", hs_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule